// File: doc/BRIEF.md
# Combining Fetch-and-Add Switch Node

This block is a two-input network node placed in front of a memory module that performs fetch-and-add atomically. Each input carries one request per handshake: a word address, an increment and a requester ID. The memory adds the increment to the addressed word and returns the value the word held before the update. Every request gets exactly one reply, on the reply port that matches the input it came in on.

When both inputs offer a request to the same word in the same cycle, the node merges them. Memory then sees one access that carries the sum of the two increments. The node keeps the input-0 increment and both IDs in a small wait buffer. When the merged reply returns, the node splits it. Input 0's requester receives the old value. Input 1's requester receives the old value plus input 0's increment. Both requesters see the result they would have seen if input 0 had gone first and input 1 had followed. This lets many requesters reach a shared counter, such as a barrier count, with fewer memory accesses.

Requests that cannot be merged are forwarded one per cycle, and input 0 wins. A merge is not possible when the addresses differ, when only one input is valid, or when the wait buffer is full.

Top module: `fa_combine_node`

## Requirements
- R1: During and right after reset, neither reply port is valid, neither input is ready while its valid is low, and every memory word reads as zero.
- R2: An accepted request applies fetch-and-add atomically. Its reply carries the word's value before the update, and the word then holds the old value plus the increment.
- R3: When both inputs are valid with equal addresses and the wait buffer has a free entry, both inputs are ready in that cycle. Memory then receives a single access whose increment is the sum of the two increments.
- R4: A merged reply appears on both reply ports in the same cycle. Port 0 carries the old value and input 0's ID. Port 1 carries the old value plus input 0's increment, and input 1's ID.
- R5: When both inputs are valid with different addresses, only input 0 is ready. A valid input 0 is always ready.
- R6: When only input 1 is valid, it is ready and is forwarded uncombined. Its reply appears only on port 1.
- R7: When the wait buffer is full (WB_DEPTH merged requests outstanding), a same-address pair is not merged. Only input 0 is accepted.
- R8: A reply appears exactly MEM_LAT cycles after the acceptance edge, on the port of the accepting input, with the requester's ID. An uncombined reply never appears on the other port.
- R9: All sums wrap modulo 2^DW, both the stored word and the split value on port 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| in0_valid | input | 1 | request offered on input 0 |
| in0_ready | output | 1 | input 0 accepted this cycle |
| in0_addr | input | AW | word address, input 0 |
| in0_inc | input | DW | increment, input 0 |
| in0_id | input | IDW | requester ID, input 0 |
| in1_valid | input | 1 | request offered on input 1 |
| in1_ready | output | 1 | input 1 accepted this cycle |
| in1_addr | input | AW | word address, input 1 |
| in1_inc | input | DW | increment, input 1 |
| in1_id | input | IDW | requester ID, input 1 |
| out0_valid | output | 1 | reply for an input-0 requester |
| out0_id | output | IDW | ID of that requester |
| out0_data | output | DW | value returned to that requester |
| out1_valid | output | 1 | reply for an input-1 requester |
| out1_id | output | IDW | ID of that requester |
| out1_data | output | DW | value returned to that requester |

## Verification
The bench builds the node with AW=2, DW=8, WB_DEPTH=2 and MEM_LAT=3. Four words make same-address collisions frequent. Eight-bit data makes the stored word and the split value wrap within a few requests. A wait buffer shallower than the reply latency fills after two back-to-back merges, so the fall-back to uncombined forwarding is exercised often rather than only in rare runs.

// File: rtl/fa_pkg.sv
package fa_pkg;
  typedef enum logic [1:0] {
    RT_NONE = 2'd0,
    RT_IN0  = 2'd1,
    RT_IN1  = 2'd2,
    RT_BOTH = 2'd3
  } route_e;
endpackage

// File: rtl/fa_arbiter.sv
module fa_arbiter import fa_pkg::*; #(
  parameter int AW = 4
) (
  input  logic          v0,
  input  logic          v1,
  input  logic [AW-1:0] a0,
  input  logic [AW-1:0] a1,
  input  logic          wb_full,
  output route_e        route
);
  always_comb begin
    if (v0 && v1 && (a0 == a1) && !wb_full) route = RT_BOTH;
    else if (v0)                            route = RT_IN0;
    else if (v1)                            route = RT_IN1;
    else                                    route = RT_NONE;
  end
endmodule

// File: rtl/fa_waitbuf.sv
module fa_waitbuf #(
  parameter int DEPTH = 4,
  parameter int DW    = 16,
  parameter int IDW   = 4,
  parameter int TW    = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           alloc,
  input  logic [DW-1:0]  alloc_inc,
  input  logic [IDW-1:0] alloc_id0,
  input  logic [IDW-1:0] alloc_id1,
  output logic [TW-1:0]  alloc_tag,
  output logic           full,
  input  logic           free,
  input  logic [TW-1:0]  free_tag,
  output logic [DW-1:0]  rd_inc,
  output logic [IDW-1:0] rd_id0,
  output logic [IDW-1:0] rd_id1
);
  logic [DEPTH-1:0] vld;
  logic [DW-1:0]    inc_q [DEPTH];
  logic [IDW-1:0]   id0_q [DEPTH];
  logic [IDW-1:0]   id1_q [DEPTH];

  assign full = &vld;

  always_comb begin
    alloc_tag = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!vld[i]) alloc_tag = TW'(i);
  end

  assign rd_inc = inc_q[free_tag];
  assign rd_id0 = id0_q[free_tag];
  assign rd_id1 = id1_q[free_tag];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        inc_q[i] <= '0;
        id0_q[i] <= '0;
        id1_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (free && (free_tag == TW'(i))) vld[i] <= 1'b0;
        if (alloc && (alloc_tag == TW'(i))) begin
          vld[i]   <= 1'b1;
          inc_q[i] <= alloc_inc;
          id0_q[i] <= alloc_id0;
          id1_q[i] <= alloc_id1;
        end
      end
    end
  end

  // R7
  wb_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> !full);

  // R4
  wb_free_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    free |-> vld[free_tag]);
endmodule

// File: rtl/fa_memory.sv
module fa_memory #(
  parameter int AW  = 4,
  parameter int DW  = 16,
  parameter int LAT = 2,
  parameter int MW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] inc,
  input  logic [MW-1:0] meta,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_old,
  output logic [MW-1:0] rsp_meta
);
  localparam int WORDS = 1 << AW;

  function automatic logic [DW-1:0] fa_sum(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return a + b;
  endfunction

  logic [DW-1:0] mem [WORDS];
  logic          pv  [LAT];
  logic [DW-1:0] pd  [LAT];
  logic [MW-1:0] pm  [LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < WORDS; j++) mem[j] <= '0;
      for (int i = 0; i < LAT; i++) begin
        pv[i] <= 1'b0;
        pd[i] <= '0;
        pm[i] <= '0;
      end
    end else begin
      pv[0] <= req;
      pd[0] <= mem[addr];
      pm[0] <= meta;
      for (int i = 1; i < LAT; i++) begin
        pv[i] <= pv[i-1];
        pd[i] <= pd[i-1];
        pm[i] <= pm[i-1];
      end
      if (req) mem[addr] <= fa_sum(mem[addr], inc);
    end
  end

  assign rsp_valid = pv[LAT-1];
  assign rsp_old   = pd[LAT-1];
  assign rsp_meta  = pm[LAT-1];
endmodule

// File: rtl/fa_combine_node.sv
module fa_combine_node import fa_pkg::*; #(
  parameter int AW       = 4,
  parameter int DW       = 16,
  parameter int IDW      = 4,
  parameter int WB_DEPTH = 4,
  parameter int MEM_LAT  = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in0_valid,
  output logic           in0_ready,
  input  logic [AW-1:0]  in0_addr,
  input  logic [DW-1:0]  in0_inc,
  input  logic [IDW-1:0] in0_id,
  input  logic           in1_valid,
  output logic           in1_ready,
  input  logic [AW-1:0]  in1_addr,
  input  logic [DW-1:0]  in1_inc,
  input  logic [IDW-1:0] in1_id,
  output logic           out0_valid,
  output logic [IDW-1:0] out0_id,
  output logic [DW-1:0]  out0_data,
  output logic           out1_valid,
  output logic [IDW-1:0] out1_id,
  output logic [DW-1:0]  out1_data
);
  localparam int TW = (WB_DEPTH > 1) ? $clog2(WB_DEPTH) : 1;
  localparam int MW = 2 + IDW + TW;

  function automatic logic [DW-1:0] merge_inc(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return a + b;
  endfunction

  function automatic logic [DW-1:0] split_second(input logic [DW-1:0] old, input logic [DW-1:0] first);
    return old + first;
  endfunction

  route_e         route;
  logic           wb_full, wb_alloc, wb_free;
  logic [TW-1:0]  wb_tag;
  logic [DW-1:0]  wb_inc;
  logic [IDW-1:0] wb_id0, wb_id1;

  logic           mem_req;
  logic [AW-1:0]  mem_addr;
  logic [DW-1:0]  mem_inc;
  logic [MW-1:0]  mem_meta;
  logic           rsp_valid;
  logic [DW-1:0]  rsp_old;
  logic [MW-1:0]  rsp_meta;

  logic           rsp_comb, rsp_side;
  logic [IDW-1:0] rsp_id;
  logic [TW-1:0]  rsp_tag;

  fa_arbiter #(.AW(AW)) u_arb (
    .v0(in0_valid), .v1(in1_valid), .a0(in0_addr), .a1(in1_addr),
    .wb_full(wb_full), .route(route)
  );

  assign in0_ready = (route == RT_IN0) || (route == RT_BOTH);
  assign in1_ready = (route == RT_IN1) || (route == RT_BOTH);
  assign wb_alloc  = (route == RT_BOTH);

  always_comb begin
    mem_req  = (route != RT_NONE);
    mem_addr = in0_addr;
    mem_inc  = in0_inc;
    mem_meta = {1'b0, 1'b0, in0_id, wb_tag};
    case (route)
      RT_BOTH: begin
        mem_inc  = merge_inc(in0_inc, in1_inc);
        mem_meta = {1'b1, 1'b0, in0_id, wb_tag};
      end
      RT_IN1: begin
        mem_addr = in1_addr;
        mem_inc  = in1_inc;
        mem_meta = {1'b0, 1'b1, in1_id, wb_tag};
      end
      default: ;
    endcase
  end

  fa_memory #(.AW(AW), .DW(DW), .LAT(MEM_LAT), .MW(MW)) u_mem (
    .clk(clk), .rst_n(rst_n), .req(mem_req), .addr(mem_addr), .inc(mem_inc),
    .meta(mem_meta), .rsp_valid(rsp_valid), .rsp_old(rsp_old), .rsp_meta(rsp_meta)
  );

  assign {rsp_comb, rsp_side, rsp_id, rsp_tag} = rsp_meta;
  assign wb_free = rsp_valid && rsp_comb;

  fa_waitbuf #(.DEPTH(WB_DEPTH), .DW(DW), .IDW(IDW), .TW(TW)) u_wb (
    .clk(clk), .rst_n(rst_n),
    .alloc(wb_alloc), .alloc_inc(in0_inc), .alloc_id0(in0_id), .alloc_id1(in1_id),
    .alloc_tag(wb_tag), .full(wb_full),
    .free(wb_free), .free_tag(rsp_tag),
    .rd_inc(wb_inc), .rd_id0(wb_id0), .rd_id1(wb_id1)
  );

  assign out0_valid = rsp_valid && (rsp_comb || !rsp_side);
  assign out1_valid = rsp_valid && (rsp_comb ||  rsp_side);
  assign out0_id    = rsp_comb ? wb_id0 : rsp_id;
  assign out1_id    = rsp_comb ? wb_id1 : rsp_id;
  assign out0_data  = rsp_old;
  assign out1_data  = rsp_comb ? split_second(rsp_old, wb_inc) : rsp_old;

  // R5
  in0_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in0_valid |-> in0_ready);

  // R3
  combine_same_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in0_valid && in1_valid && in0_ready && in1_ready) |-> (in0_addr == in1_addr));
endmodule

// File: tb/sim_fa_combine_node.sv
`timescale 1ns/1ps
module sim_fa_combine_node;
  localparam int AW = 2, DW = 8, IDW = 3, WBD = 2, LAT = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic in0_valid, in0_ready, in1_valid, in1_ready;
  logic [AW-1:0] in0_addr, in1_addr;
  logic [DW-1:0] in0_inc, in1_inc;
  logic [IDW-1:0] in0_id, in1_id;
  logic out0_valid, out1_valid;
  logic [IDW-1:0] out0_id, out1_id;
  logic [DW-1:0] out0_data, out1_data;

  fa_combine_node #(.AW(AW), .DW(DW), .IDW(IDW), .WB_DEPTH(WBD), .MEM_LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n),
    .in0_valid(in0_valid), .in0_ready(in0_ready), .in0_addr(in0_addr), .in0_inc(in0_inc), .in0_id(in0_id),
    .in1_valid(in1_valid), .in1_ready(in1_ready), .in1_addr(in1_addr), .in1_inc(in1_inc), .in1_id(in1_id),
    .out0_valid(out0_valid), .out0_id(out0_id), .out0_data(out0_data),
    .out1_valid(out1_valid), .out1_id(out1_id), .out1_data(out1_data)
  );

  typedef struct {
    int due; bit comb; bit side;
    logic [IDW-1:0] id0, id1;
    logic [DW-1:0] d0, d1;
  } pend_t;

  pend_t pq[$];
  logic [DW-1:0] mm [1<<AW];
  int cyc = 0, checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual=%0d expected=%0d", tag, what, cyc, act, exp);
    end
  endtask

  task automatic step(bit v0, int a0, int i0, int d0, bit v1, int a1, int i1, int d1);
    bit e0v, e1v, ecomb, full, r0, r1;
    logic [IDW-1:0] e0id, e1id;
    logic [DW-1:0] e0d, e1d, old;
    int occ;
    string tg;
    pend_t p;
    e0v = 0; e1v = 0; ecomb = 0; e0id = '0; e1id = '0; e0d = '0; e1d = '0; occ = 0;
    while (pq.size() > 0 && pq[0].due < cyc) void'(pq.pop_front());
    foreach (pq[k]) begin
      if (pq[k].due == cyc) begin
        ecomb = pq[k].comb;
        if (pq[k].comb || !pq[k].side) begin e0v = 1; e0id = pq[k].id0; e0d = pq[k].d0; end
        if (pq[k].comb ||  pq[k].side) begin e1v = 1; e1id = pq[k].id1; e1d = pq[k].d1; end
      end
      if (pq[k].comb && pq[k].due >= cyc) occ++;
    end
    tg = ecomb ? "R4" : "R8";
    chk(out0_valid == e0v, tg, "out0_valid", int'(out0_valid), int'(e0v));
    chk(out1_valid == e1v, tg, "out1_valid", int'(out1_valid), int'(e1v));
    if (e0v && out0_valid) begin
      chk(out0_id == e0id, tg, "out0_id", int'(out0_id), int'(e0id));
      chk(out0_data == e0d, "R2 R9", "out0_data", int'(out0_data), int'(e0d));
    end
    if (e1v && out1_valid) begin
      chk(out1_id == e1id, tg, "out1_id", int'(out1_id), int'(e1id));
      chk(out1_data == e1d, ecomb ? "R4 R9" : "R2 R6", "out1_data", int'(out1_data), int'(e1d));
    end

    in0_valid = v0; in0_addr = AW'(a0); in0_inc = DW'(i0); in0_id = IDW'(d0);
    in1_valid = v1; in1_addr = AW'(a1); in1_inc = DW'(i1); in1_id = IDW'(d1);
    #1;
    full = (occ >= WBD);
    r0 = v0;
    r1 = v1 && (!v0 || ((AW'(a0) == AW'(a1)) && !full));
    if (v0 && v1 && (AW'(a0) == AW'(a1))) tg = full ? "R7" : "R3";
    else if (v0 && v1) tg = "R5";
    else if (v1) tg = "R6";
    else tg = "R1";
    chk(in0_ready == r0, tg, "in0_ready", int'(in0_ready), int'(r0));
    chk(in1_ready == r1, tg, "in1_ready", int'(in1_ready), int'(r1));

    p.due = cyc + LAT;
    if (r0 && r1) begin
      old = mm[AW'(a0)];
      mm[AW'(a0)] = old + DW'(i0) + DW'(i1);
      p.comb = 1; p.side = 0; p.id0 = IDW'(d0); p.id1 = IDW'(d1);
      p.d0 = old; p.d1 = old + DW'(i0);
      pq.push_back(p);
    end else if (r0 || r1) begin
      p.comb = 0; p.side = r1;
      p.id0 = r1 ? IDW'(d1) : IDW'(d0); p.id1 = p.id0;
      old = mm[r1 ? AW'(a1) : AW'(a0)];
      mm[r1 ? AW'(a1) : AW'(a0)] = old + (r1 ? DW'(i1) : DW'(i0));
      p.d0 = old; p.d1 = old;
      pq.push_back(p);
    end
    @(negedge clk);
    cyc++;
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R8 watchdog expired: actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    foreach (mm[j]) mm[j] = '0;
    rst_n = 0;
    in0_valid = 0; in1_valid = 0; in0_addr = '0; in1_addr = '0;
    in0_inc = '0; in1_inc = '0; in0_id = '0; in1_id = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!out0_valid, "R1", "out0_valid in reset", int'(out0_valid), 0);
    chk(!out1_valid, "R1", "out1_valid in reset", int'(out1_valid), 0);
    chk(!in0_ready && !in1_ready, "R1", "ready in reset", int'(in0_ready | in1_ready), 0);
    rst_n = 1;
    @(negedge clk);
    // R1 memory reads zero
    for (int a = 0; a < (1 << AW); a++) step(1, a, 0, a, 0, 0, 0, 0);
    // R2 preload 5, then R3/R4: 3 and 1 merged -> 5 and 8, word 9
    step(1, 1, 5, 1, 0, 0, 0, 0);
    step(1, 1, 3, 2, 1, 1, 1, 3);
    step(1, 1, 0, 4, 0, 0, 0, 0);
    // R5 different addresses
    step(1, 0, 7, 5, 1, 2, 9, 6);
    // R6 input 1 only
    step(0, 0, 0, 0, 1, 3, 4, 7);
    // R7 back-to-back merges fill the wait buffer
    for (int k = 0; k < 4; k++) step(1, 2, k + 1, k, 1, 2, 10, k + 4);
    // R9 wrap
    step(1, 3, 200, 1, 0, 0, 0, 0);
    step(1, 3, 200, 2, 1, 3, 250, 3);
    repeat (LAT + 2) step(0, 0, 0, 0, 0, 0, 0, 0);
    // random traffic in three mixes
    for (int k = 0; k < 3000; k++) begin
      int mode, a0, a1;
      mode = k / 1000;
      a0 = $urandom_range(0, (1 << AW) - 1);
      a1 = (mode == 0 || $urandom_range(0, 1) == 1) ? a0 : $urandom_range(0, (1 << AW) - 1);
      step(mode == 2 ? ($urandom_range(0, 3) == 0) : ($urandom_range(0, 3) != 0), a0,
           $urandom_range(0, 255), $urandom_range(0, 7),
           $urandom_range(0, 3) != 0, a1, $urandom_range(0, 255), $urandom_range(0, 7));
    end
    repeat (LAT + 2) step(0, 0, 0, 0, 0, 0, 0, 0);
    finish_run();
  end
endmodule